// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a chip's peripheral request lines and its DMA channel engines. Each request line owns one map entry. An entry holds a valid flag and a target channel number. The block passes every request line through a two-flop synchroniser. It then steers each synchronised line to the channel named by its entry, but only while that entry's valid flag is set. The result is one request bit per channel, which feeds the channel engines. Channel arbitration and the data movement itself happen downstream and are not part of this block.

Software programs the entries over a simple register bus. The entries are split by request number into two address windows. Request numbers 0 to 63 use the low window. Request numbers 64 and up use the high window. When several valid entries name the same channel, their synchronised lines are ORed onto that channel's request bit. Writing an all-zero word to an entry unmaps its line. The block has no state machine: the entry table is the only state that matters, and it changes only through bus writes and reset.

Top module: `req_chan_mapper`

## Requirements
- R1: The entry for request n (n < 64) sits at byte address 0x0100 + 4·n.
- R2: The entry for request n (64 ≤ n < 128) sits at byte address 0x1100 + 4·(n − 64).
- R3: Entry word layout: bit 7 is the valid flag and bits 4:0 are the channel number. A read returns exactly these bits, with every other bit zero. Read data appears on `bus_rdata` in the cycle after the read strobe and is held until the next read.
- R4: `ch_req[c]` is 1 exactly when some synchronised request line is high and its entry is valid and names channel c.
- R5: A change on `req_in` reaches `ch_req` after the second rising clock edge. It has no effect after the first edge alone.
- R6: Writing zero to an entry unmaps the line. Its request then reaches no channel, and that includes channel 0.
- R7: A line whose entry has the valid flag clear drives no channel, whatever channel number the entry holds.
- R8: Reset clears every entry. While cleared, `ch_req` is zero and every entry reads as zero.
- R9: A bus access is ignored in three cases: the address is outside both windows, the address is not word aligned, or it selects a request number at or above NUM_REQ. Writes to such an address change no entry, and reads of it return zero.
- R10: When several valid entries name the same channel, that channel's output is the OR of their synchronised lines.
- R11: An entry keeps its value in every cycle that carries no write to its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_in | input | NUM_REQ | Asynchronous peripheral request lines |
| ch_req | output | NUM_CH | Per-channel request vector |

## Verification
The assertions check four properties on every cycle:
- the synchroniser output equals the request input from two edges earlier;
- entries never change without a decoded write;
- read data never carries bits outside the valid and channel fields, and reads of unmapped addresses return zero;
- a channel request never rises unless some valid synchronised line exists.

Other behaviour can only be shown by the bench's scenarios, because it depends on what was programmed before:
- that each window maps to the right request numbers;
- that a channel request goes to the right channel;
- that a zero write or a cleared valid flag actually stops a line;
- that lines sharing a channel are merged.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned CHAN_FLD_W  = 5;
    localparam int unsigned VALID_POS   = 7;
    localparam int unsigned WIN_ENTRIES = 64;
    localparam int unsigned WIN_BYTES   = 4 * WIN_ENTRIES;

    typedef logic [CHAN_FLD_W-1:0] chan_fld_t;

    // Build the word a read returns from one entry's stored fields.
    function automatic logic [REG_W-1:0] entry_word(input logic vld, input chan_fld_t ch);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[VALID_POS]           = vld;
        w[CHAN_FLD_W-1:0]      = ch;
        return w;
    endfunction

endpackage

// File: rtl/reqmap_sync.sv
module reqmap_sync #(
    parameter int unsigned WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // Counts edges since reset so the latency check looks back only through non-reset cycles.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    // R5
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/reqmap_decode.sv
module reqmap_decode #(
    parameter int unsigned          NUM_REQ = 128,
    parameter int unsigned          ADDR_W  = 16,
    parameter logic [ADDR_W-1:0]    LO_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0]    HI_BASE = 16'h1100,
    localparam int unsigned         IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    import reqmap_pkg::*;

    localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] lo_off;
    logic [ADDR_W-1:0] hi_off;
    logic              aligned;
    logic              in_lo;
    logic              in_hi;

    assign lo_off  = addr - LO_BASE;
    assign hi_off  = addr - HI_BASE;
    assign aligned = (addr[1:0] == 2'b00);
    assign in_lo   = (addr >= LO_BASE) && (lo_off < WIN_SPAN);
    assign in_hi   = (addr >= HI_BASE) && (hi_off < WIN_SPAN);

    always_comb begin
        int n;
        if (aligned && in_lo)      n = int'(lo_off >> 2);
        else if (aligned && in_hi) n = int'(WIN_ENTRIES) + int'(hi_off >> 2);
        else                       n = -1;
        hit = (n >= 0) && (n < int'(NUM_REQ));
        idx = hit ? IDX_W'(n) : '0;
    end

endmodule

// File: rtl/reqmap_table.sv
module reqmap_table #(
    parameter int unsigned NUM_REQ = 128,
    localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_en,
    input  logic                                        rd_en,
    input  logic                                        hit,
    input  logic [IDX_W-1:0]                            idx,
    input  logic [reqmap_pkg::REG_W-1:0]                wdata,
    output logic [reqmap_pkg::REG_W-1:0]                rdata,
    output logic [NUM_REQ-1:0]                          valid_vec,
    output logic [NUM_REQ-1:0][reqmap_pkg::CHAN_FLD_W-1:0] chan_vec
);
    import reqmap_pkg::*;

    logic [NUM_REQ-1:0]                 valid_q;
    logic [NUM_REQ-1:0][CHAN_FLD_W-1:0] chan_q;
    logic [REG_W-1:0]                   rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            chan_q  <= '0;
        end else if (wr_en && hit) begin
            for (int r = 0; r < int'(NUM_REQ); r++) begin
                if (idx == IDX_W'(r)) begin
                    valid_q[r] <= wdata[VALID_POS];
                    chan_q[r]  <= wdata[CHAN_FLD_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= hit ? entry_word(valid_q[idx], chan_q[idx]) : '0;
    end

    assign rdata     = rdata_q;
    assign valid_vec = valid_q;
    assign chan_vec  = chan_q;

    // R11
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit) |=> ($stable(valid_q) && $stable(chan_q)));

    // R3
    read_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata[REG_W-1:VALID_POS+1] == '0 &&
                   rdata[VALID_POS-1:CHAN_FLD_W] == '0));

    // R9
    miss_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rdata == '0));

endmodule

// File: rtl/reqmap_route.sv
module reqmap_route #(
    parameter int unsigned NUM_REQ = 128,
    parameter int unsigned NUM_CH  = 32,
    localparam int unsigned CH_IW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [NUM_REQ-1:0]                             req_sync,
    input  logic [NUM_REQ-1:0]                             valid_vec,
    input  logic [NUM_REQ-1:0][reqmap_pkg::CHAN_FLD_W-1:0] chan_vec,
    output logic [NUM_CH-1:0]                              ch_req
);

    logic [NUM_REQ-1:0] live;
    assign live = req_sync & valid_vec;

    always_comb begin
        ch_req = '0;
        for (int r = 0; r < int'(NUM_REQ); r++) begin
            if (live[r] && (int'(chan_vec[r]) < int'(NUM_CH)))
                ch_req[chan_vec[r][CH_IW-1:0]] = 1'b1;
        end
    end

    // R4
    route_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_req) |-> (|live));

endmodule

// File: rtl/req_chan_mapper.sv
module req_chan_mapper #(
    parameter int unsigned       NUM_REQ = 128,
    parameter int unsigned       NUM_CH  = 32,
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] LO_BASE = 16'h0100,
    parameter logic [ADDR_W-1:0] HI_BASE = 16'h1100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0]  ch_req
);
    import reqmap_pkg::*;

    localparam int unsigned IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    logic                               acc_hit;
    logic [IDX_W-1:0]                   acc_idx;
    logic [NUM_REQ-1:0]                 req_sync;
    logic [NUM_REQ-1:0]                 valid_vec;
    logic [NUM_REQ-1:0][CHAN_FLD_W-1:0] chan_vec;

    reqmap_decode #(
        .NUM_REQ (NUM_REQ),
        .ADDR_W  (ADDR_W),
        .LO_BASE (LO_BASE),
        .HI_BASE (HI_BASE)
    ) u_decode (
        .addr (bus_addr),
        .hit  (acc_hit),
        .idx  (acc_idx)
    );

    reqmap_table #(
        .NUM_REQ (NUM_REQ)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .rd_en     (bus_rd_en),
        .hit       (acc_hit),
        .idx       (acc_idx),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .valid_vec (valid_vec),
        .chan_vec  (chan_vec)
    );

    reqmap_sync #(
        .WIDTH (NUM_REQ)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_in),
        .sync_out (req_sync)
    );

    reqmap_route #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .valid_vec (valid_vec),
        .chan_vec  (chan_vec),
        .ch_req    (ch_req)
    );

endmodule

// File: tb/sim_req_chan_mapper.sv
module sim_req_chan_mapper;

    localparam int NR = 128;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr_en;
    logic          bus_rd_en;
    logic [15:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NR-1:0] req_in;
    logic [NC-1:0] ch_req;

    always #10 clk = ~clk;

    req_chan_mapper u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_in    (req_in),
        .ch_req    (ch_req)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic       exp_valid [NR];
    logic [4:0] exp_chan  [NR];

    function automatic logic [15:0] ent_addr(int n);
        return (n < 64) ? 16'(16'h0100 + 4 * n) : 16'(16'h1100 + 4 * (n - 64));
    endfunction

    function automatic logic [31:0] ent_word(int n);
        return {24'b0, exp_valid[n], 2'b00, exp_chan[n]};
    endfunction

    function automatic logic [NC-1:0] route(logic [NR-1:0] rv);
        logic [NC-1:0] o = '0;
        for (int r = 0; r < NR; r++)
            if (rv[r] && exp_valid[r]) o[exp_chan[r]] = 1'b1;
        return o;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic map_write(int n, logic [31:0] d);
        bus_write(ent_addr(n), d);
        exp_valid[n] = d[7];
        exp_chan[n]  = d[4:0];
    endtask

    task automatic bus_read(logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_req(logic [NR-1:0] v);
        @(negedge clk); req_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < NR; r++) begin exp_valid[r] = 1'b0; exp_chan[r] = 5'd0; end
    endtask

    task automatic readback_all(string tag);
        logic [31:0] d;
        for (int r = 0; r < NR; r++) begin
            bus_read(ent_addr(r), d);
            chk(tag, d, ent_word(r));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0]   d;
        logic [NR-1:0] rv;
        logic [15:0]   ba;
        void'($urandom(32'd20240611));
        bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0; req_in = '0;
        do_reset();

        // R8: cleared after reset
        chk("R8 ch_req after reset", 32'(ch_req), 32'h0);
        bus_read(16'h0100, d); chk("R8 entry 0", d, 0);
        bus_read(16'h11FC, d); chk("R8 entry 127", d, 0);

        // R1, R3, R5: request 5 to channel 3
        map_write(5, 32'h0000_0083);
        bus_read(16'h0114, d); chk("R1 entry 5 readback", d, 32'h83);
        @(negedge clk); req_in = NR'(1) << 5;
        @(negedge clk); chk("R5 after one edge", 32'(ch_req), 32'h0);
        @(negedge clk); chk("R5 after two edges", 32'(ch_req), 32'h8);

        // R2: request 70 to channel 31
        map_write(70, 32'h0000_009F);
        bus_read(16'h1118, d); chk("R2 entry 70 readback", d, 32'h9F);
        set_req((NR'(1) << 5) | (NR'(1) << 70));
        chk("R2 route 70", 32'(ch_req), 32'h8000_0008);

        // R3: stray bits in a write are not stored
        map_write(0, 32'hFFFF_FF9F);
        bus_read(16'h0100, d); chk("R3 field mask", d, 32'h9F);

        // R7: valid clear, channel 7 named
        map_write(10, 32'h0000_0007);
        set_req(NR'(1) << 10);
        chk("R7 invalid entry silent", 32'(ch_req), 32'h0);
        bus_read(ent_addr(10), d); chk("R7 readback", d, 32'h07);

        // R6: zero write unmaps, including from channel 0
        map_write(12, 32'h0000_0080);
        set_req((NR'(1) << 5) | (NR'(1) << 12));
        chk("R6 before unmap", 32'(ch_req), 32'h9);
        map_write(5, 32'h0);
        @(negedge clk);
        chk("R6 entry 5 unmapped", 32'(ch_req), 32'h1);
        map_write(12, 32'h0);
        @(negedge clk);
        chk("R6 entry 12 unmapped", 32'(ch_req), 32'h0);

        // R10: two lines share channel 9
        map_write(1, 32'h89); map_write(2, 32'h89);
        set_req(NR'(6)); chk("R10 both", 32'(ch_req), 32'h200);
        set_req(NR'(4)); chk("R10 one", 32'(ch_req), 32'h200);
        set_req(NR'(0)); chk("R10 none", 32'(ch_req), 32'h0);

        // R9: misses ignored on write, zero on read
        for (int i = 0; i < 40; i++) begin
            ba = 16'($urandom());
            if (ba[15:8] == 8'h01 || ba[15:8] == 8'h11) ba[0] = 1'b1;
            if (i == 0) ba = 16'h0102;
            if (i == 1) ba = 16'h0200;
            if (i == 2) ba = 16'h10FC;
            bus_write(ba, 32'h0000_0095);
            bus_read(ba, d);
            chk("R9 miss read", d, 32'h0);
        end
        readback_all("R9 R11 entries untouched");

        // R4: random programming and requests against the model
        for (int i = 0; i < 300; i++) begin
            map_write(int'($urandom_range(0, NR - 1)), $urandom());
            rv = {$urandom(), $urandom(), $urandom(), $urandom()};
            set_req(rv);
            chk("R4 random route", 32'(ch_req), 32'(route(rv)));
        end
        readback_all("R1 R2 R3 R11 final readback");

        // R8: reset clears a programmed table
        rv = '1;
        set_req(rv);
        do_reset();
        @(negedge clk);
        chk("R8 ch_req after reapplied reset", 32'(ch_req), 32'h0);
        bus_read(16'h0100, d); chk("R8 entry 0 cleared", d, 0);
        bus_read(16'h1118, d); chk("R8 entry 70 cleared", d, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule